// File: doc/BRIEF.md
# Prioritised Level Interrupt Controller

This block collects level-sensitive interrupt lines from a small set of sources and routes them to a few processor contexts through a word-addressed register bus with single-cycle access. Software gives each source a priority. For each context it sets an enable mask and a threshold. For every context the block picks the best eligible pending source and drives a request line to that context while one exists.

Servicing an interrupt takes two register operations on one address per context. A read claims the current winner: it returns the winner's ID and removes that source from arbitration in the same cycle. A later write of that ID completes the service, and the source's input is sampled again. Source ID 0 is reserved, and a claim that returns 0 means nothing was eligible.

Top module: `irq_hub`

## Requirements
- R1: A synchronous active-high `rst` clears every priority, enable mask, threshold, pending bit and in-service bit. While no source is pending, `ctx_irq` is 0 and claim reads return 0.
- R2: Source s (1..NSRC) has a priority word at byte address 4*s. Only the low PRIO_W bits are stored, and reads return them zero-extended. Address 0 reads 0.
- R3: The enable word of context c is at 0x2000 + 0x80*c, and bit s enables source s. Bit 0 always reads 0.
- R4: The threshold of context c is at 0x200000 + 0x1000*c and keeps PRIO_W bits. The claim/complete word of context c is at that address + 4.
- R5: Input bit `irq_in[k]` is source k+1. A high level on a source that is not in service makes the source pending at the next clock edge. The pending bit stays set until the source is claimed.
- R6: Source s is eligible for context c when it is pending, enabled for c, and its priority is strictly greater than c's threshold. `ctx_irq[c]` is high exactly while some source is eligible for c.
- R7: Among eligible sources the highest priority wins. On a tie the lowest ID wins.
- R8: A claim read of context c returns the winner's ID (0 if none). At that edge it clears the winner's pending bit and marks the source in service. A source in service is never pending, even while its input stays high, so no two claims can return the same source.
- R9: A completion write carrying the ID of a source in service releases it. If its input is still high, the source is pending again one cycle later.
- R10: A completion write carrying 0, an ID above NSRC, or the ID of a source not in service changes nothing.
- R11: A source with priority 0 never interrupts. A threshold of all ones (2^PRIO_W-1) blocks every source for that context.
- R12: Reads of unmapped or non-word-aligned addresses return 0, and writes to them are dropped. This includes enable words past word 0 and contexts at or above NCTX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NSRC | Level interrupt inputs; bit k is source k+1 |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 22 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_en` |
| ctx_irq | output | NCTX | Interrupt request line per context |

## Verification
The hardest state to reach from the ports mixes several kinds of source at once. Some sources are in service with their inputs still high, others are pending but below threshold, and a tie sits among the rest. The bench reaches this by holding inputs high across a series of claims. Each successive claim must then skip the sources already taken and finally return 0, even though every input is still asserted. Stray completion writes, threshold and priority changes, and a second context sharing a source then check that release happens only for a genuine in-service ID and that one source cannot be claimed twice.

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [21:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCTX-1:0]   ctx_irq
);
  localparam int IDW = $clog2(NSRC + 1);

  logic [PRIO_W-1:0] prio [1:NSRC];
  logic [NSRC:1]     en   [NCTX];
  logic [PRIO_W-1:0] thr  [NCTX];
  logic [IDW-1:0]    win  [NCTX];
  logic [NSRC:1]     pend, busy;

  logic aligned, in_prio, in_en, in_ctl;
  assign aligned = bus_addr[1:0] == 2'b00;
  assign in_prio = aligned && bus_addr[21:12] == 10'd0;
  assign in_en   = aligned && bus_addr[21:13] == 9'd1 && bus_addr[6:2] == 5'd0;
  assign in_ctl  = aligned && bus_addr[21];

  logic [NCTX-1:0] en_sel, thr_sel, clm_sel;
  always_comb begin
    for (int c = 0; c < NCTX; c++) begin
      en_sel[c]  = in_en  && bus_addr[12:7]  == 6'(c);
      thr_sel[c] = in_ctl && bus_addr[20:12] == 9'(c) && bus_addr[11:0] == 12'h000;
      clm_sel[c] = in_ctl && bus_addr[20:12] == 9'(c) && bus_addr[11:0] == 12'h004;
    end
  end

  logic claim_rd, cmpl_wr;
  logic [IDW-1:0] claim_id;
  assign claim_rd = bus_en && !bus_we && (|clm_sel);
  assign cmpl_wr  = bus_en &&  bus_we && (|clm_sel);

  always_comb begin
    for (int c = 0; c < NCTX; c++) begin
      logic [PRIO_W-1:0] best;
      best   = thr[c];
      win[c] = '0;
      for (int s = 1; s <= NSRC; s++)
        if (pend[s] && en[c][s] && prio[s] > best) begin
          best   = prio[s];
          win[c] = IDW'(s);
        end
      ctx_irq[c] = win[c] != '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    claim_id  = '0;
    for (int s = 1; s <= NSRC; s++)
      if (in_prio && bus_addr[11:2] == 10'(s)) bus_rdata = 32'(prio[s]);
    for (int c = 0; c < NCTX; c++) begin
      if (en_sel[c])  bus_rdata = 32'({en[c], 1'b0});
      if (thr_sel[c]) bus_rdata = 32'(thr[c]);
      if (clm_sel[c]) begin
        bus_rdata = 32'(win[c]);
        claim_id  = win[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      busy <= '0;
      for (int s = 1; s <= NSRC; s++) prio[s] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        en[c]  <= '0;
        thr[c] <= '0;
      end
    end else begin
      for (int s = 1; s <= NSRC; s++) begin
        if (claim_rd && claim_id == IDW'(s)) begin
          pend[s] <= 1'b0;
          busy[s] <= 1'b1;
        end else if (cmpl_wr && bus_wdata == 32'(s) && busy[s]) begin
          busy[s] <= 1'b0;
        end else if (!busy[s] && irq_in[s-1]) begin
          pend[s] <= 1'b1;
        end
        if (bus_en && bus_we && in_prio && bus_addr[11:2] == 10'(s))
          prio[s] <= bus_wdata[PRIO_W-1:0];
      end
      for (int c = 0; c < NCTX; c++) begin
        if (bus_en && bus_we && en_sel[c])  en[c]  <= bus_wdata[NSRC:1];
        if (bus_en && bus_we && thr_sel[c]) thr[c] <= bus_wdata[PRIO_W-1:0];
      end
    end
  end
endmodule

module irq_hub_chk #(
  parameter int NSRC = 31,
  parameter int NCTX = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_en,
  input logic            bus_we,
  input logic [21:0]     bus_addr,
  input logic [31:0]     bus_rdata,
  input logic [NCTX-1:0] ctx_irq,
  input logic [NSRC:1]   pend,
  input logic [NSRC:1]   busy
);
  logic          clm;
  logic [8:0]    cx;
  logic [NSRC:0] m;
  assign cx  = bus_addr[20:12];
  assign clm = bus_en && !bus_we && bus_addr[21] && bus_addr[1:0] == 2'b00 &&
               bus_addr[11:2] == 10'd1 && 32'(cx) < NCTX;
  assign m   = (NSRC + 1)'(1) << bus_rdata;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (ctx_irq == '0 && pend == '0 && busy == '0));

  assert_no_double_claim_R8: assert property (@(posedge clk) disable iff (rst)
    (pend & busy) == '0);

  assert_claim_takes_R8: assert property (@(posedge clk) disable iff (rst)
    (clm && bus_rdata != 0 && bus_rdata <= NSRC) |=> (({busy, 1'b0} & $past(m)) == $past(m)));

  assert_idle_claim_R6: assert property (@(posedge clk) disable iff (rst)
    (clm && !ctx_irq[cx]) |-> bus_rdata == 32'd0);

  assert_quiet_when_empty_R6: assert property (@(posedge clk) disable iff (rst)
    pend == '0 |-> ctx_irq == '0);
endmodule

bind irq_hub irq_hub_chk #(.NSRC(NSRC), .NCTX(NCTX)) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .ctx_irq(ctx_irq), .pend(pend), .busy(busy)
);

// File: tb/sim_irq_hub.sv
`timescale 1ns/1ps
module sim_irq_hub;
  localparam int NSRC = 31;
  localparam int NCTX = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] irq_in = '0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [21:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCTX-1:0] ctx_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_hub #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(3)) u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctx_irq(ctx_irq)
  );

  function automatic logic [21:0] PRI(int s); return 22'(4 * s); endfunction
  function automatic logic [21:0] ENA(int c); return 22'(32'h2000 + 32'h80 * c); endfunction
  function automatic logic [21:0] THR(int c); return 22'(32'h200000 + 32'h1000 * c); endfunction
  function automatic logic [21:0] CLM(int c); return 22'(32'h200004 + 32'h1000 * c); endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [21:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [21:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic rd_chk(string tag, logic [21:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  // {write, addr, wdata, expected read}, requirement number
  localparam int NV = 16;
  localparam logic [86:0] VEC [NV] = '{
    {1'b1, 22'h000014, 32'h000000FF, 32'h0},        // R2 priority of source 5
    {1'b0, 22'h000014, 32'h0,        32'h7},        // R2 truncated to 3 bits
    {1'b0, 22'h000000, 32'h0,        32'h0},        // R2 source 0 has no register
    {1'b1, 22'h002000, 32'hFFFFFFFF, 32'h0},        // R3
    {1'b0, 22'h002000, 32'h0,        32'hFFFFFFFE}, // R3 bit 0 reads 0
    {1'b1, 22'h002080, 32'h0000000B, 32'h0},        // R3 context 1
    {1'b0, 22'h002080, 32'h0,        32'h0000000A}, // R3
    {1'b1, 22'h200000, 32'h00000012, 32'h0},        // R4 threshold
    {1'b0, 22'h200000, 32'h0,        32'h2},        // R4
    {1'b1, 22'h001000, 32'h00000005, 32'h0},        // R12 unmapped write
    {1'b0, 22'h001000, 32'h0,        32'h0},        // R12
    {1'b0, 22'h002004, 32'h0,        32'h0},        // R12 enable word 1
    {1'b1, 22'h202000, 32'h00000003, 32'h0},        // R12 context 2
    {1'b0, 22'h202000, 32'h0,        32'h0},        // R12
    {1'b0, 22'h000015, 32'h0,        32'h0},        // R12 misaligned
    {1'b0, 22'h200004, 32'h0,        32'h0}         // R4 claim with nothing pending
  };
  localparam int VREQ [NV] = '{2,2,2,3,3,3,3,4,4,12,12,12,12,12,12,4};

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1 check("R1 ctx_irq after reset", 32'(ctx_irq), 32'h0);
    rd_chk("R1 claim after reset", CLM(0), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][86]) wr(VEC[i][85:64], VEC[i][63:32]);
      else begin
        logic [31:0] d;
        rd(VEC[i][85:64], d);
        checks++;
        if (d !== VEC[i][31:0]) begin
          errors++;
          $display("FAIL R%0d vector %0d: actual %0h expected %0h", VREQ[i], i, d, VEC[i][31:0]);
        end
      end
    end

    do_reset();
    rd_chk("R1 priority cleared", PRI(5), 32'h0);
    rd_chk("R1 enable cleared", ENA(0), 32'h0);
    rd_chk("R1 threshold cleared", THR(0), 32'h0);

    wr(PRI(3), 4); wr(PRI(5), 4); wr(PRI(7), 6); wr(PRI(2), 1);
    wr(ENA(0), 32'hAC);
    wr(THR(0), 1);
    @(negedge clk); irq_in = 31'h14;       // sources 3 and 5
    settle();
    check("R5 R6 request raised", 32'(ctx_irq), 32'h1);
    rd_chk("R7 tie to lowest ID", CLM(0), 3);
    rd_chk("R8 second claim", CLM(0), 5);
    rd_chk("R8 in-service sources held out", CLM(0), 0);
    #1 check("R8 request drops", 32'(ctx_irq), 32'h0);

    @(negedge clk); irq_in = 31'h56;       // add sources 2 and 7
    settle();
    rd_chk("R7 highest priority", CLM(0), 7);
    #1 check("R6 priority equal to threshold", 32'(ctx_irq), 32'h0);
    rd_chk("R6 no eligible source", CLM(0), 0);

    wr(CLM(0), 9); wr(CLM(0), 0); wr(CLM(0), 40);
    rd_chk("R10 bogus completions ignored", CLM(0), 0);
    wr(CLM(0), 3);
    rd_chk("R9 completion re-arms", CLM(0), 3);

    wr(THR(0), 7);
    wr(CLM(0), 5);
    settle();
    check("R11 all-ones threshold", 32'(ctx_irq), 32'h0);
    rd_chk("R11 claim blocked", CLM(0), 0);

    wr(THR(0), 0);
    wr(ENA(0), 32'hA8);
    wr(PRI(5), 0);
    settle();
    check("R11 zero priority", 32'(ctx_irq), 32'h0);
    rd_chk("R11 zero priority claim", CLM(0), 0);

    wr(PRI(5), 2);
    wr(ENA(1), 32'h20);
    wr(THR(1), 0);
    settle();
    check("R6 both contexts see source 5", 32'(ctx_irq), 32'h3);
    rd_chk("R4 context 1 claim", CLM(1), 5);
    rd_chk("R8 no second claim from context 0", CLM(0), 0);
    #1 check("R8 both requests drop", 32'(ctx_irq), 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule